// File: doc/BRIEF.md
# External Bus Access Stretch Controller

This block carries single read and write transfers from an on-chip master to a slow, asynchronous memory or peripheral that sits outside the chip. The master presents an address, a direction and write data when the controller reports itself ready. The controller then drives the off-chip select, direction, address and data lines for a stretched interval, and finally returns the read data with a one-clock completion pulse.

The length of each transfer comes from one of two sources, chosen per transfer. In the programmed mode, a 3-bit setting adds a fixed number of stretch cycles after the basic cycle. In the wait-driven mode, the programmed setting is set aside. The device lengthens the transfer through an asynchronous wait line, which the block passes through its own two-flop synchronizer. Both configuration inputs are sampled when a request is accepted, so they may change freely while a transfer is running.

Top module: `ext_stretch_ctrl`

## Requirements
- R1: After reset, `ext_cs` and `rsp_done` are low and `req_ready` is high.
- R2: A request is taken only while `req_ready` is high. `req_ready` falls in the cycle after acceptance and stays low while `ext_cs` is high and during the `rsp_done` cycle.
- R3: With `cfg_wait_en` low at acceptance, a `cfg_stretch` value n keeps `ext_cs` high for exactly n+2 cycles: one basic cycle plus n+1 stretch cycles. Changing `cfg_stretch` after acceptance has no effect on the running transfer.
- R4: With `cfg_wait_en` low at acceptance, the level of `ext_wait` has no effect on the transfer length.
- R5: With `cfg_wait_en` high and `ext_wait` never asserted, `ext_cs` stays high for exactly 3 cycles (two stretch cycles), whatever the value of `cfg_stretch`.
- R6: With `cfg_wait_en` high, `ext_wait` (active high) passes through a two-flop synchronizer. If `ext_wait` is high from well before acceptance and is first sampled low by the clock edge m cycles after acceptance (m >= 1), `ext_cs` stays high for m+3 cycles. There is no upper limit.
- R7: While `ext_cs` is high, `ext_addr`, `ext_rw` (1 = read, 0 = write), `ext_wdata` and `ext_data_oe` hold steady. `ext_rw` is low and `ext_data_oe` is high exactly for write transfers.
- R8: On a read, `rsp_rdata` takes the `ext_rdata` value present during the last cycle in which `ext_cs` is high.
- R9: `ext_cs` falls on the clock edge that ends the final access cycle. In that same cycle `rsp_done` is high, for exactly one clock, and `req_ready` is high again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Master presents a transfer |
| req_ready | output | 1 | Controller idle and able to take a transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (16) | Transfer address |
| req_wdata | input | DATA_W (16) | Write data |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | DATA_W (16) | Captured read data |
| cfg_stretch | input | CFG_W (3) | Programmed stretch setting n (n+1 stretch cycles) |
| cfg_wait_en | input | 1 | Select the wait-driven length mode |
| ext_wait | input | 1 | Asynchronous wait request from the device, active high |
| ext_cs | output | 1 | Off-chip select, active high for the whole transfer |
| ext_rw | output | 1 | Off-chip direction, 1 = read |
| ext_data_oe | output | 1 | Enable for the off-chip data drivers during writes |
| ext_addr | output | ADDR_W (16) | Off-chip address |
| ext_wdata | output | DATA_W (16) | Off-chip write data |
| ext_rdata | input | DATA_W (16) | Off-chip read data |

## Verification
The bench sweeps every programmed setting, then changes the setting right after acceptance. An off-by-one in the stretch count, or reading the live setting, would show up as a transfer that is one cycle short or long. A bench memory returns read data that changes every cycle of the transfer. Capturing one cycle early or late therefore returns a visibly wrong word. In wait mode, the wait line is released at several offsets, including one far beyond eight cycles. This exposes a synchronizer with the wrong depth, a missing two-cycle minimum, or a hidden cap on the wait stretch. A held wait line in the programmed mode catches a design that obeys the wait line when it should not.

// File: rtl/ebs_pkg.sv
package ebs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_BASE    = 2'd1,
    ST_STRETCH = 2'd2,
    ST_DONE    = 2'd3
  } ebs_state_e;
endpackage

// File: rtl/ebs_wait_sync.sv
module ebs_wait_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= async_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], async_in};
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/ebs_seq.sv
module ebs_seq
  import ebs_pkg::*;
#(
  parameter int CFG_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CFG_W-1:0] cfg_n,
  input  logic             cfg_wait_en,
  input  logic             wait_s,
  output ebs_state_e       state,
  output logic             last_cycle
);
  localparam int CNT_W = CFG_W + 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CFG_W-1:0] n_q;
  logic             wmode_q;
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] fixed_end;

  assign fixed_end = {1'b0, n_q} + CNT_W'(1);

  always_comb begin
    last_cycle = 1'b0;
    if (state == ST_STRETCH) begin
      if (wmode_q) last_cycle = armed_q;
      else         last_cycle = (cnt_q == fixed_end);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      n_q     <= '0;
      wmode_q <= 1'b0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (start) begin
            state   <= ST_BASE;
            n_q     <= cfg_n;
            wmode_q <= cfg_wait_en;
            armed_q <= 1'b0;
            cnt_q   <= '0;
          end
        end
        ST_BASE: begin
          state <= ST_STRETCH;
          cnt_q <= CNT_W'(1);
        end
        ST_STRETCH: begin
          if (last_cycle) begin
            state <= ST_DONE;
          end else begin
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_W'(1);
            if (wmode_q && !armed_q && !wait_s) armed_q <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5: the wait-driven mode never finishes on its first stretch cycle
  p_wait_min_two_r5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STRETCH && wmode_q && cnt_q == CNT_W'(1)) |-> !last_cycle);

  // R3: the programmed mode never counts past its latched setting
  p_fixed_bound_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STRETCH && !wmode_q) |-> (cnt_q <= fixed_end));

  // R6: a wait sampled high before arming keeps the transfer going
  p_wait_extends_r6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_STRETCH && wmode_q && !armed_q && wait_s) |=> (state == ST_STRETCH));
endmodule

// File: rtl/ebs_pins.sv
module ebs_pins #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              last_cycle,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] ext_rdata,
  output logic              ext_cs,
  output logic              ext_rw,
  output logic              ext_data_oe,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ext_cs      <= 1'b0;
      ext_rw      <= 1'b1;
      ext_data_oe <= 1'b0;
      ext_addr    <= '0;
      ext_wdata   <= '0;
      rsp_done    <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      rsp_done <= last_cycle;
      if (start) begin
        ext_cs      <= 1'b1;
        ext_rw      <= !req_write;
        ext_data_oe <= req_write;
        ext_addr    <= req_addr;
        ext_wdata   <= req_wdata;
      end else if (last_cycle) begin
        ext_cs      <= 1'b0;
        ext_data_oe <= 1'b0;
        if (ext_rw) rsp_rdata <= ext_rdata;
      end
    end
  end

  // R9: completion lasts one clock
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  // R9: select release and completion coincide
  p_done_at_release_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(ext_cs) |-> rsp_done);

  // R7: pins hold while the select is active
  p_pins_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (ext_cs && $past(ext_cs)) |-> ($stable(ext_addr) && $stable(ext_wdata) && $stable(ext_rw)));
endmodule

// File: rtl/ext_stretch_ctrl.sv
module ext_stretch_ctrl
  import ebs_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 16,
  parameter int CFG_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [CFG_W-1:0]  cfg_stretch,
  input  logic              cfg_wait_en,
  input  logic              ext_wait,
  output logic              ext_cs,
  output logic              ext_rw,
  output logic              ext_data_oe,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  input  logic [DATA_W-1:0] ext_rdata
);
  ebs_state_e state;
  logic       last_cycle;
  logic       wait_s;
  logic       start;

  assign req_ready = (state == ST_IDLE);
  assign start     = req_valid && req_ready;

  ebs_wait_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (ext_wait),
    .sync_out (wait_s)
  );

  ebs_seq #(.CFG_W(CFG_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .cfg_n       (cfg_stretch),
    .cfg_wait_en (cfg_wait_en),
    .wait_s      (wait_s),
    .state       (state),
    .last_cycle  (last_cycle)
  );

  ebs_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .last_cycle  (last_cycle),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .ext_rdata   (ext_rdata),
    .ext_cs      (ext_cs),
    .ext_rw      (ext_rw),
    .ext_data_oe (ext_data_oe),
    .ext_addr    (ext_addr),
    .ext_wdata   (ext_wdata),
    .rsp_done    (rsp_done),
    .rsp_rdata   (rsp_rdata)
  );

  // R2: an accepted request drives the select next cycle and drops ready
  p_accept_idle_r2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (ext_cs && !req_ready));

  // R2: never ready while the off-chip transfer is active
  p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (rst)
    ext_cs |-> !req_ready);
endmodule

// File: tb/ext_stretch_ctrl_tb.sv
module ext_stretch_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic [2:0]  cfg_stretch = '0;
  logic        cfg_wait_en = 1'b0;
  logic        ext_wait = 1'b0;
  logic        ext_cs;
  logic        ext_rw;
  logic        ext_data_oe;
  logic [15:0] ext_addr;
  logic [15:0] ext_wdata;
  logic [15:0] ext_rdata = '0;

  int total = 0;
  int bad = 0;

  typedef struct {
    bit          wr;
    logic [15:0] addr;
    logic [15:0] wdata;
    int          len;
    string       tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ext_stretch_ctrl u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .cfg_stretch(cfg_stretch),
    .cfg_wait_en(cfg_wait_en), .ext_wait(ext_wait), .ext_cs(ext_cs),
    .ext_rw(ext_rw), .ext_data_oe(ext_data_oe), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
  );

  function automatic logic [15:0] mix(input logic [15:0] a, input int cyc);
    return a ^ 16'hA5A5 ^ 16'(cyc * 16'h0101);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor and bus model
  bit          prev_cs = 0;
  int          len = 0;
  logic [15:0] a0, w0;
  logic        r0, o0;
  bit          stable_ok;

  always @(negedge clk) begin
    if (rst) begin
      prev_cs = 0;
      len = 0;
    end else begin
      if (ext_cs) begin
        if (!prev_cs) begin
          len = 1; a0 = ext_addr; w0 = ext_wdata; r0 = ext_rw; o0 = ext_data_oe;
          stable_ok = 1;
        end else begin
          len++;
          if (ext_addr !== a0 || ext_wdata !== w0 || ext_rw !== r0 || ext_data_oe !== o0)
            stable_ok = 0;
        end
        ext_rdata = mix(ext_addr, len - 1);
      end else begin
        ext_rdata = 16'h0;
        if (prev_cs) begin
          exp_t e;
          chk(rsp_done === 1'b1, "R9 done with select release", int'(rsp_done), 1);
          chk(req_ready === 1'b0, "R2 not ready in done cycle", int'(req_ready), 0);
          if (q.size() == 0) begin
            chk(0, "R2 unexpected transfer", 1, 0);
          end else begin
            e = q.pop_front();
            chk(len == e.len, {e.tag, " select length"}, len, e.len);
            chk(a0 === e.addr, "R7 address", int'(a0), int'(e.addr));
            chk(r0 === !e.wr && o0 === e.wr, "R7 direction/oe", int'({r0, o0}), int'({!e.wr, e.wr}));
            chk(stable_ok, "R7 pins stable", int'(stable_ok), 1);
            if (e.wr) chk(w0 === e.wdata, "R7 write data", int'(w0), int'(e.wdata));
            else      chk(rsp_rdata === mix(e.addr, e.len - 1), "R8 read capture",
                          int'(rsp_rdata), int'(mix(e.addr, e.len - 1)));
          end
        end else if (rsp_done) begin
          chk(0, "R9 spurious done", 1, 0);
        end
      end
      prev_cs = ext_cs;
    end
  end

  // driver: m < 0 means ext_wait stays low; otherwise it is held high and,
  // in wait mode, released at the m-th falling edge after acceptance
  task automatic access(input bit wr, input logic [15:0] addr, input logic [15:0] wd,
                        input int n, input bit wen, input int m, input string tag);
    exp_t e;
    @(negedge clk);
    ext_wait = (m >= 0);
    repeat (3) @(negedge clk);
    cfg_stretch = 3'(n);
    cfg_wait_en = wen;
    req_valid = 1; req_write = wr; req_addr = addr; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    e.wr = wr; e.addr = addr; e.wdata = wd; e.tag = tag;
    e.len = wen ? ((m < 0) ? 3 : m + 3) : n + 2;
    q.push_back(e);
    @(negedge clk);
    req_valid = 0;
    req_addr = ~addr; req_wdata = ~wd; req_write = !wr;
    cfg_stretch = ~3'(n);         // R3: ignored after acceptance
    if (wen && m >= 1) begin
      repeat (m - 1) @(negedge clk);
      ext_wait = 0;
    end
    while (!rsp_done) @(negedge clk);
    @(negedge clk);
    chk(req_ready === 1'b1, "R9 ready after done", int'(req_ready), 1);
    ext_wait = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL R9 watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(ext_cs === 1'b0 && rsp_done === 1'b0 && req_ready === 1'b1, "R1 reset state",
        int'({ext_cs, rsp_done, req_ready}), 1);
    for (int n = 0; n < 8; n++)
      access(n[0], 16'h1000 + 16'(n * 16'h111), 16'hBEE0 + 16'(n), n, 0, -1, "R3");
    access(0, 16'h2222, 16'h0, 3, 0, 5, "R4");
    access(1, 16'h2468, 16'h7777, 6, 0, 2, "R4");
    access(0, 16'h3333, 16'h0, 7, 1, -1, "R5");
    access(1, 16'h3434, 16'h5A5A, 0, 1, -1, "R5");
    access(0, 16'h4001, 16'h0, 2, 1, 1, "R6");
    access(1, 16'h4002, 16'hC3C3, 5, 1, 2, "R6");
    access(0, 16'h4005, 16'h0, 0, 1, 5, "R6");
    access(0, 16'h4014, 16'h0, 7, 1, 20, "R6");
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R2 all transfers seen", q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule